// File: doc/BRIEF.md
# Bipolar Watch Stepping-Motor Pulse Generator

This block produces the drive pulses for a two-terminal bipolar stepping motor of the kind found in quartz wrist-watches. It runs on a 32768 Hz clock; every clock cycle is one tick. Each step puts one pulse on one of the two motor terminals, and consecutive steps use opposite terminals, so the coil current reverses from one step to the next.

The shape of the pulse follows the state of the battery, which another block reports on a two-bit input. A fresh lithium cell gets a chopped pulse that is driven three ticks out of every four. A silver-oxide cell gets a solid pulse. An exhausted cell also gets a solid pulse, but normal stepping is replaced by a group of four closely spaced steps once per long frame, which the wearer sees as a warning. Two test selections shorten the step period; one of them also takes the pulse width from a calibration input. A stop input takes both terminals to high impedance and restarts the step timing, so that a watch can be set to the second.

Top module: `stepper_pulse_gen`

## Requirements
- R1: While rst_n is low (sampled at the clock), all four outputs are 0. In the first cycle after release with stop low, both enables are 1 and the first pulse appears on m1_drv (positive polarity) with m2_drv at 0.
- R2: With test_sel = 0 and batt_mode = 1 or 0, a pulse starts at the first tick of every STEP_CLKS period and lasts PULSE_CLKS ticks; outside it both drive outputs are 0.
- R3: Each completed pulse flips the polarity, so successive pulses alternate between m1_drv and m2_drv; the two drive outputs are never 1 together.
- R4: With batt_mode = 1 (lithium), a pulse is chopped: counting ticks from the start of the pulse, tick i is driven when i mod 4 is 0, 1 or 2 and off when it is 3.
- R5: With batt_mode = 0 (silver-oxide) or 3 (treated as silver-oxide), the pulse is driven on every tick of its width.
- R6: With batt_mode = 2 (end-of-life) and test_sel = 0 or 3, a frame lasts EOL_CLKS ticks and holds BURST_N (4) unchopped pulses starting at ticks 0, GAP_CLKS, 2·GAP_CLKS and 3·GAP_CLKS of the frame.
- R7: With test_sel = 1, the period is TEST_CLKS ticks and the width PULSE_CLKS, whatever batt_mode says; end-of-life bursts are suppressed but chopping still follows batt_mode.
- R8: With test_sel = 2, the period is TEST_CLKS ticks and the width is cal_n·UNIT_CLKS ticks; cal_n = 0 produces no pulse and no polarity change.
- R9: While stop is 1, both enables and both drives are 0. Timing restarts so that the first cycle after stop falls starts a pulse, and its polarity follows the last completed pulse; a pulse cut short by stop does not flip the polarity.
- R10: test_sel = 3 behaves as test_sel = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop | input | 1 | Holds the motor idle with outputs released |
| batt_mode | input | 2 | 0 silver-oxide, 1 lithium, 2 end-of-life, 3 as 0 |
| test_sel | input | 2 | 0 normal, 1 fast period, 2 calibration check, 3 as 0 |
| cal_n | input | CAL_W | Pulse width in units of UNIT_CLKS for test_sel = 2 |
| m1_drv | output | 1 | Drive level for motor terminal 1 |
| m1_oe | output | 1 | Output enable for terminal 1 (0 = high impedance) |
| m2_drv | output | 1 | Drive level for motor terminal 2 |
| m2_oe | output | 1 | Output enable for terminal 2 (0 = high impedance) |

## Verification
The generator is run in every combination of battery state and test selection, with segments long enough to cover more than one period, so that period length, pulse width, chop pattern and burst spacing each show up as a distinct tick-by-tick waveform. Segments separated by stop compare polarity carry-over after complete and after interrupted pulses, which distinguishes toggling on pulse end from toggling on pulse start. Calibration values of zero and of several non-zero widths separate the computed width from the fixed one, and the reserved codes 3 on both selects show that they fall back to the plain behaviour.

// File: rtl/stepper_pkg.sv
// Shared encodings for the stepping-motor pulse generator.
// Assumes both selects arrive as two-bit codes from neighbouring blocks.
package stepper_pkg;

    typedef enum logic [1:0] {
        BATT_SILVER  = 2'd0,
        BATT_LITHIUM = 2'd1,
        BATT_EOL     = 2'd2,
        BATT_RSVD    = 2'd3
    } batt_e;

    typedef enum logic [1:0] {
        TST_NONE = 2'd0,
        TST_FAST = 2'd1,
        TST_CAL  = 2'd2,
        TST_RSVD = 2'd3
    } tst_e;

endpackage

// File: rtl/step_timer.sv
// Step timing: a frame counter, a slot counter and a slot index.
// A frame holds one slot in normal and test modes and BURST_N pulse slots
// in end-of-life mode. A pulse is active for the first `width` ticks of
// each pulse slot. Assumes width < slot length and frame >= BURST_N slots.
module step_timer
    import stepper_pkg::*;
#(
    parameter int CNT_W      = 18,
    parameter int PH_W       = 2,
    parameter int CAL_W      = 6,
    parameter int STEP_CLKS  = 32768,
    parameter int PULSE_CLKS = 256,
    parameter int TEST_CLKS  = 1024,
    parameter int GAP_CLKS   = 2048,
    parameter int EOL_CLKS   = 131072,
    parameter int BURST_N    = 4,
    parameter int UNIT_CLKS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  batt_e            batt,
    input  tst_e             tst,
    input  logic [CAL_W-1:0] cal_n,
    output logic             pulse_on,
    output logic             pulse_last,
    output logic [PH_W-1:0]  phase
);

    localparam int IDX_W = $clog2(BURST_N + 1);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    logic [CNT_W-1:0] frm_cnt, slot_cnt;
    logic [IDX_W-1:0] slot_idx;
    logic [CNT_W-1:0] frame_len, slot_len, width;
    logic [IDX_W-1:0] n_slots;
    logic             short_mode, burst_mode, frame_end, slot_end;

    // Mode decode: period, slot length, slot count and pulse width.
    always_comb begin
        short_mode = (tst == TST_FAST) || (tst == TST_CAL);
        burst_mode = (batt == BATT_EOL) && !short_mode;
        if (short_mode)      frame_len = CNT_W'(TEST_CLKS);
        else if (burst_mode) frame_len = CNT_W'(EOL_CLKS);
        else                 frame_len = CNT_W'(STEP_CLKS);
        slot_len = burst_mode ? CNT_W'(GAP_CLKS) : frame_len;
        n_slots  = burst_mode ? IDX_W'(BURST_N) : IDX_W'(1);
        if (tst == TST_CAL) width = CNT_W'(cal_n) * CNT_W'(UNIT_CLKS);
        else                width = CNT_W'(PULSE_CLKS);
        frame_end = frm_cnt  >= frame_len - CNT_W'(1);
        slot_end  = slot_cnt >= slot_len  - CNT_W'(1);
    end

    // Advance the counters; stop and reset park them at the frame start.
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            frm_cnt  <= '0;
            slot_cnt <= '0;
            slot_idx <= '0;
        end else begin
            frm_cnt  <= frame_end ? '0 : frm_cnt + CNT_W'(1);
            slot_cnt <= (frame_end || slot_end) ? '0 : slot_cnt + CNT_W'(1);
            if (frame_end)
                slot_idx <= '0;
            else if (slot_end && slot_idx != IDX_MAX)
                slot_idx <= slot_idx + IDX_W'(1);
        end
    end

    // Pulse window and its final tick.
    always_comb begin
        pulse_on   = !stop && (slot_idx < n_slots) && (slot_cnt < width);
        pulse_last = pulse_on && (slot_cnt == width - CNT_W'(1));
        phase      = slot_cnt[PH_W-1:0];
    end

endmodule

// File: rtl/pulse_shaper.sv
// Polarity and chopping. Holds the polarity flag, flips it at the last tick
// of every pulse, and masks the pulse with the chop carrier in lithium mode.
// Assumes CHOP_LEN is a power of two and phase counts from pulse start.
module pulse_shaper
    import stepper_pkg::*;
#(
    parameter int CHOP_LEN = 4,
    parameter int CHOP_ON  = 3,
    localparam int PH_W    = $clog2(CHOP_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  batt_e           batt,
    input  logic            pulse_on,
    input  logic            pulse_last,
    input  logic [PH_W-1:0] phase,
    output logic            drv_pos,
    output logic            drv_neg
);

    logic pol_q;
    logic chop_ok, drive;

    // Polarity flag: 0 drives terminal 1, flips after each full pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          pol_q <= 1'b0;
        else if (pulse_last) pol_q <= !pol_q;
    end

    // Chop gate and routing of the pulse to one terminal.
    always_comb begin
        chop_ok = (batt == BATT_LITHIUM) ? (phase < PH_W'(CHOP_ON)) : 1'b1;
        drive   = pulse_on && chop_ok;
        drv_pos = drive && !pol_q;
        drv_neg = drive && pol_q;
    end

endmodule

// File: rtl/stepper_pulse_gen.sv
// Top of the stepping-motor pulse generator. One clock cycle is one tick
// of the 32768 Hz time base. Enables go low during reset and stop, which
// the analog pad stage turns into high impedance.
module stepper_pulse_gen
    import stepper_pkg::*;
#(
    parameter int STEP_CLKS  = 32768,
    parameter int PULSE_CLKS = 256,
    parameter int TEST_CLKS  = 1024,
    parameter int GAP_CLKS   = 2048,
    parameter int EOL_CLKS   = 131072,
    parameter int BURST_N    = 4,
    parameter int UNIT_CLKS  = 4,
    parameter int CAL_W      = 6,
    parameter int CHOP_LEN   = 4,
    parameter int CHOP_ON    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic [1:0]       batt_mode,
    input  logic [1:0]       test_sel,
    input  logic [CAL_W-1:0] cal_n,
    output logic             m1_drv,
    output logic             m1_oe,
    output logic             m2_drv,
    output logic             m2_oe
);

    localparam int MAX_LEN = (EOL_CLKS > STEP_CLKS) ? EOL_CLKS : STEP_CLKS;
    localparam int CNT_W   = $clog2(MAX_LEN + 1) + 1;
    localparam int PH_W    = $clog2(CHOP_LEN);

    batt_e           batt;
    tst_e            tst;
    logic            pulse_on, pulse_last;
    logic [PH_W-1:0] phase;
    logic            drv_pos, drv_neg;

    assign batt = batt_e'(batt_mode);
    assign tst  = tst_e'(test_sel);

    step_timer #(
        .CNT_W(CNT_W), .PH_W(PH_W), .CAL_W(CAL_W),
        .STEP_CLKS(STEP_CLKS), .PULSE_CLKS(PULSE_CLKS),
        .TEST_CLKS(TEST_CLKS), .GAP_CLKS(GAP_CLKS),
        .EOL_CLKS(EOL_CLKS), .BURST_N(BURST_N), .UNIT_CLKS(UNIT_CLKS)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .stop(stop), .batt(batt), .tst(tst),
        .cal_n(cal_n), .pulse_on(pulse_on), .pulse_last(pulse_last),
        .phase(phase)
    );

    pulse_shaper #(
        .CHOP_LEN(CHOP_LEN), .CHOP_ON(CHOP_ON)
    ) shaper_i (
        .clk(clk), .rst_n(rst_n), .batt(batt), .pulse_on(pulse_on),
        .pulse_last(pulse_last), .phase(phase),
        .drv_pos(drv_pos), .drv_neg(drv_neg)
    );

    // Output stage: drives and enables are released in reset and stop.
    always_comb begin
        m1_oe  = rst_n && !stop;
        m2_oe  = rst_n && !stop;
        m1_drv = rst_n && drv_pos;
        m2_drv = rst_n && drv_neg;
    end

endmodule

// File: rtl/stepper_pulse_gen_chk.sv
// Property checker for the pulse generator, bound to every instance.
module stepper_pulse_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop,
    input logic [1:0] batt_mode,
    input logic [1:0] test_sel,
    input logic       m1_drv,
    input logic       m1_oe,
    input logic       m2_drv,
    input logic       m2_oe
);

    logic drv;
    assign drv = m1_drv || m2_drv;

    // R3: terminals are never driven together.
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(m1_drv && m2_drv));

    // R9: stop releases both terminals.
    assert_stop_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> (!m1_oe && !m2_oe && !m1_drv && !m2_drv));

    // R9: while running, both terminals are enabled.
    assert_run_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stop |-> (m1_oe && m2_oe));

    // R1: first cycle out of reset never drives the negative terminal.
    assert_first_positive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !m2_drv);

    // R4: lithium pulses never stay on for four ticks in a row.
    assert_lith_chop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_mode == 2'd1 && $past(batt_mode) == 2'd1 &&
         $past(batt_mode, 2) == 2'd1 && $past(batt_mode, 3) == 2'd1 &&
         test_sel == $past(test_sel) && test_sel == $past(test_sel, 2) &&
         test_sel == $past(test_sel, 3) &&
         $past(drv) && $past(drv, 2) && $past(drv, 3)) |-> !drv);

endmodule

bind stepper_pulse_gen stepper_pulse_gen_chk chk_i (.*);

// File: tb/stepper_pulse_gen_tb.sv
// Self-checking bench: directed segments then seeded random segments,
// each compared tick by tick with a reference computed from the rules.
module stepper_pulse_gen_tb_top;

    localparam int STEP  = 200;
    localparam int PULSE = 20;
    localparam int TPER  = 64;
    localparam int GAP   = 40;
    localparam int EOL   = 400;
    localparam int UNIT  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop = 1'b0;
    logic [1:0] batt_mode = 2'd0;
    logic [1:0] test_sel = 2'd0;
    logic [5:0] cal_n = 6'd0;
    logic       m1_drv, m1_oe, m2_drv, m2_oe;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    bit  pol = 1'b0;

    always #5 clk = !clk;

    stepper_pulse_gen #(
        .STEP_CLKS(STEP), .PULSE_CLKS(PULSE), .TEST_CLKS(TPER),
        .GAP_CLKS(GAP), .EOL_CLKS(EOL), .BURST_N(4), .UNIT_CLKS(UNIT),
        .CAL_W(6), .CHOP_LEN(4), .CHOP_ON(3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .stop(stop), .batt_mode(batt_mode),
        .test_sel(test_sel), .cal_n(cal_n), .m1_drv(m1_drv), .m1_oe(m1_oe),
        .m2_drv(m2_drv), .m2_oe(m2_oe)
    );

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {m1_oe,m2_oe,m1_drv,m2_drv} actual=%b expected=%b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag();
        if (test_sel == 2'd2) return "R8";
        if (test_sel == 2'd1) return "R7";
        if (batt_mode == 2'd2) return (test_sel == 2'd3) ? "R10" : "R6";
        if (test_sel == 2'd3) return "R10";
        if (batt_mode == 2'd1) return "R4";
        if (batt_mode == 2'd3) return "R5";
        return "R2";
    endfunction

    // Reference: is tick k of a segment inside a pulse, and its offset.
    function automatic bit ref_on(int k, output int off, output int w);
        bit short_m = (test_sel == 2'd1) || (test_sel == 2'd2);
        bit burst_m = (batt_mode == 2'd2) && !short_m;
        int frame = short_m ? TPER : (burst_m ? EOL : STEP);
        int f = k % frame;
        w = (test_sel == 2'd2) ? int'(cal_n) * UNIT : PULSE;
        if (burst_m) begin
            off = f % GAP;
            return (f / GAP < 4) && (off < w);
        end
        off = f;
        return f < w;
    endfunction

    // Runs one segment starting with the first tick after release.
    task automatic run_seg(int len);
        string tag = mode_tag();
        for (int k = 0; k < len; k++) begin
            int  off, w;
            bit  on, drv;
            if (k > 0) @(negedge clk);
            #1;
            on  = ref_on(k, off, w);
            drv = on && ((batt_mode != 2'd1) || (off % 4 < 3));
            check((k == 0) ? {tag, "/R3/R9"} : {tag, "/R3"},
                  {m1_oe, m2_oe, m1_drv, m2_drv},
                  {1'b1, 1'b1, drv && !pol, drv && pol});
            if (on && off == w - 1) pol = !pol;
        end
    endtask

    // Stops, applies a new mode, checks the idle outputs, releases.
    task automatic new_seg(logic [1:0] b, logic [1:0] t, logic [5:0] c, int len);
        @(negedge clk);
        stop = 1'b1;
        batt_mode = b;
        test_sel = t;
        cal_n = c;
        #1 check("R9 stop", {m1_oe, m2_oe, m1_drv, m2_drv}, 4'b0000);
        @(negedge clk);
        #1 check("R9 stop", {m1_oe, m2_oe, m1_drv, m2_drv}, 4'b0000);
        @(negedge clk);
        stop = 1'b0;
        run_seg(len);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1 check("R1 reset", {m1_oe, m2_oe, m1_drv, m2_drv}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        run_seg(450);                       // R1 first pulse, R2, R3
        new_seg(2'd1, 2'd0, 6'd0, 250);     // R4 lithium chop
        new_seg(2'd2, 2'd0, 6'd0, 450);     // R6 end-of-life bursts
        new_seg(2'd2, 2'd1, 6'd0, 150);     // R7 bursts suppressed
        new_seg(2'd1, 2'd1, 6'd0, 150);     // R7 with chopping
        new_seg(2'd0, 2'd2, 6'd5, 150);     // R8 width 20
        new_seg(2'd0, 2'd2, 6'd0, 100);     // R8 zero width
        new_seg(2'd1, 2'd2, 6'd15, 150);    // R8 maximum used width
        new_seg(2'd1, 2'd3, 6'd0, 250);     // R10 reserved test code
        new_seg(2'd3, 2'd0, 6'd0, 250);     // R5 reserved battery code
        new_seg(2'd0, 2'd0, 6'd0, 10);      // R9 pulse cut by stop
        new_seg(2'd0, 2'd0, 6'd0, 30);      // R9 polarity unchanged
        for (int i = 0; i < 14; i++) begin
            logic [1:0] b = 2'($urandom % 4);
            logic [1:0] t = 2'($urandom % 4);
            logic [5:0] c = 6'($urandom % 16);
            new_seg(b, t, c, 20 + int'($urandom % 430));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule